// File: doc/BRIEF.md
# Clock-Profile Coincidence Window Generator

This block turns a five-bit clock-phase profile into a timing window for coincidence tests. On an accepted configuration strobe it expands the profile into an eleven-slot wrapped sequence. It then walks that sequence one slot per clock, looking for the first low-to-high transition and for the first high-to-low transition that follows it.

The slot times sit on a 5 ns grid. The grid origin depends on how the reset setting compares with the latch setting. The fine delay moves both found edges later in steps of 10 ps. All times are signed integers in 10 ps units, so one grid step is 500 units.

Two helper stages use windows. A merge stage takes two windows and forms their union or their intersection, one cycle after a merge strobe. It also flags the case where the two windows do not overlap. A hit stage reports, without a clock delay, whether a hit time lies strictly inside the most recently generated window.

Top module: `cwin_gen`

## Requirements
- R1: After reset, `win_done` and `mrg_done` are 0, `win_start` and `win_stop` are 0, and `win_none` is 1.
- R2: Slot 0 holds profile bit 0. Slots 1..5 and slots 6..10 each hold profile bits 4,3,2,1,0 in that order. Slot i has time BASE + 500*i. BASE is -500 when `cfg_reset` >= `cfg_latch` and -3000 when `cfg_reset` < `cfg_latch`.
- R3: Slots 1..10 are scanned in rising order. `win_start` is the time of the first slot that is 1 while the slot before it is 0, plus `cfg_delay`.
- R4: `win_stop` is the time of the first slot after the start slot that is 0 while the slot before it is 1, plus `cfg_delay`. Once this slot is found, later slots have no effect.
- R5: If no rising slot exists (profile all zeros or all ones), `win_start` = `win_stop` = 0 and `win_none` = 1. If a rising slot has no falling slot after it, `win_stop` = 0 and `win_none` = 1. Otherwise `win_none` = 0.
- R6: `win_done` is a one-cycle pulse. It rises exactly 10 cycles after the clock edge that accepts `cfg_valid`. The window outputs change only together with `win_done` and hold between pulses.
- R7: A `cfg_valid` that arrives while a scan is in progress is ignored and leaves the pending result unchanged.
- R8: With `mrg_and` = 0, the merged window starts at the earlier of the two starts and stops at the later of the two stops.
- R9: With `mrg_and` = 1, the merged window starts at the later of the two starts and stops at the earlier of the two stops.
- R10: `mrg_apart` is 1 exactly when `a_start` > `b_stop` or `b_start` > `a_stop`. The merged window is still produced in that case.
- R11: `mrg_done` and the merge results appear one cycle after the edge that samples `mrg_valid` and hold until the next merge.
- R12: `hit_coinc` is 1 exactly when `win_start` < `hit_time` < `win_stop`, with both comparisons strict. It follows `hit_time` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Starts a scan when idle |
| cfg_profile | input | PW (5) | Clock-phase profile word |
| cfg_latch | input | LW (8) | Latch setting |
| cfg_reset | input | LW (8) | Reset setting |
| cfg_delay | input | DW (10) | Fine delay, 10 ps units |
| win_done | output | 1 | Window-ready pulse |
| win_start | output | TW (16) | Window start, signed |
| win_stop | output | TW (16) | Window stop, signed |
| win_none | output | 1 | No complete window found |
| mrg_valid | input | 1 | Merge strobe |
| mrg_and | input | 1 | 1 = intersection, 0 = union |
| a_start | input | TW | Window A start, signed |
| a_stop | input | TW | Window A stop, signed |
| b_start | input | TW | Window B start, signed |
| b_stop | input | TW | Window B stop, signed |
| mrg_done | output | 1 | Merge result valid pulse |
| mrg_start | output | TW | Merged start, signed |
| mrg_stop | output | TW | Merged stop, signed |
| mrg_apart | output | 1 | Windows do not overlap |
| hit_time | input | TW | Hit time to test, signed |
| hit_coinc | output | 1 | Hit strictly inside window |

## Verification
The bench drives inputs and samples outputs on falling edges. The window result is due on the tenth falling edge after the one that follows the accepting rising edge. The bench checks that `win_done` is still low one edge earlier, that the values are present at the due edge, and that the pulse has dropped one edge later while the values hold. Merge results are checked at the first falling edge after the strobe was sampled. The hit flag is checked one nanosecond after `hit_time` changes, with no clock edge in between.

// File: rtl/cwin_pkg.sv
package cwin_pkg;

   typedef enum logic {MRG_UNION = 1'b0, MRG_ISECT = 1'b1} mrg_mode_e;

   // time of one slot on the grid, in 10 ps units
   function automatic int slot_time(input int base, input int step, input int idx);
      return base + step * idx;
   endfunction

endpackage

// File: rtl/cwin_scan.sv
module cwin_scan #(
   parameter int PW      = 5,
   parameter int LW      = 8,
   parameter int DW      = 10,
   parameter int TW      = 16,
   parameter int STEP    = 500,
   parameter int BASE_HI = -500,
   parameter int BASE_LO = -3000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [PW-1:0]        profile_i,
   input  logic [LW-1:0]        latch_i,
   input  logic [LW-1:0]        reset_i,
   input  logic [DW-1:0]        delay_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic signed [TW-1:0] start_o,
   output logic signed [TW-1:0] stop_o,
   output logic                 none_o
);
   import cwin_pkg::*;

   localparam int SLOTS = 2 * PW + 1;
   localparam int LAST  = SLOTS - 1;
   localparam int IW    = $clog2(SLOTS);

   if (PW < 2) begin : g_bad_pw
      $error("cwin_scan: PW must be at least 2");
   end
   if (TW < 8) begin : g_bad_tw
      $error("cwin_scan: TW too narrow");
   end

   // wrapped expansion of the profile
   logic [SLOTS-1:0] slot_exp;
   assign slot_exp[0] = profile_i[0];
   for (genvar j = 0; j < PW; j++) begin : g_exp
      assign slot_exp[1 + j]      = profile_i[PW - 1 - j];
      assign slot_exp[1 + PW + j] = profile_i[PW - 1 - j];
   end

   logic [SLOTS-1:0] slot_q;
   logic [IW-1:0]    idx_q, ridx_q, fidx_q, ridx_n, fidx_n;
   logic             rise_q, fall_q, rise_n, fall_n;
   logic             busy_q;
   logic             base_hi_q;
   logic [DW-1:0]    dly_q;
   logic             prev_bit, cur_bit;
   logic signed [TW-1:0] st_n, sp_n;
   logic signed [TW-1:0] dly_ext;
   int               base_v;

   assign prev_bit = slot_q[idx_q - IW'(1)];
   assign cur_bit  = slot_q[idx_q];
   assign base_v   = base_hi_q ? BASE_HI : BASE_LO;
   assign dly_ext  = TW'(dly_q);

   always_comb begin
      rise_n = rise_q;
      ridx_n = ridx_q;
      fall_n = fall_q;
      fidx_n = fidx_q;
      if (busy_q) begin
         if (!rise_q && !prev_bit && cur_bit) begin
            rise_n = 1'b1;
            ridx_n = idx_q;
         end else if (rise_q && !fall_q && prev_bit && !cur_bit) begin
            fall_n = 1'b1;
            fidx_n = idx_q;
         end
      end
   end

   always_comb begin
      st_n = '0;
      sp_n = '0;
      if (rise_n)
         st_n = TW'(slot_time(base_v, STEP, int'(ridx_n))) + dly_ext;
      if (rise_n && fall_n)
         sp_n = TW'(slot_time(base_v, STEP, int'(fidx_n))) + dly_ext;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q    <= '0;
         idx_q     <= '0;
         ridx_q    <= '0;
         fidx_q    <= '0;
         rise_q    <= 1'b0;
         fall_q    <= 1'b0;
         busy_q    <= 1'b0;
         base_hi_q <= 1'b1;
         dly_q     <= '0;
         done_o    <= 1'b0;
         start_o   <= '0;
         stop_o    <= '0;
         none_o    <= 1'b1;
      end else begin
         done_o <= 1'b0;
         if (!busy_q && start_i) begin
            slot_q    <= slot_exp;
            base_hi_q <= (reset_i >= latch_i);
            dly_q     <= delay_i;
            idx_q     <= IW'(1);
            rise_q    <= 1'b0;
            fall_q    <= 1'b0;
            ridx_q    <= '0;
            fidx_q    <= '0;
            busy_q    <= 1'b1;
         end else if (busy_q) begin
            rise_q <= rise_n;
            ridx_q <= ridx_n;
            fall_q <= fall_n;
            fidx_q <= fidx_n;
            if (idx_q == IW'(LAST)) begin
               busy_q  <= 1'b0;
               done_o  <= 1'b1;
               start_o <= st_n;
               stop_o  <= sp_n;
               none_o  <= !(rise_n && fall_n);
            end else begin
               idx_q <= idx_q + IW'(1);
            end
         end
      end
   end

   assign busy_o = busy_q;

endmodule

// File: rtl/cwin_merge.sv
module cwin_merge #(
   parameter int TW      = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid_i,
   input  logic                 and_i,
   input  logic signed [TW-1:0] a_start_i,
   input  logic signed [TW-1:0] a_stop_i,
   input  logic signed [TW-1:0] b_start_i,
   input  logic signed [TW-1:0] b_stop_i,
   output logic                 done_o,
   output logic signed [TW-1:0] start_o,
   output logic signed [TW-1:0] stop_o,
   output logic                 apart_o
);
   import cwin_pkg::*;

   logic signed [TW-1:0] early_st, late_st, early_sp, late_sp, m_st, m_sp;
   logic                 m_apart;
   mrg_mode_e            mode;

   assign mode     = mrg_mode_e'(and_i);
   assign early_st = (a_start_i < b_start_i) ? a_start_i : b_start_i;
   assign late_st  = (a_start_i > b_start_i) ? a_start_i : b_start_i;
   assign early_sp = (a_stop_i < b_stop_i) ? a_stop_i : b_stop_i;
   assign late_sp  = (a_stop_i > b_stop_i) ? a_stop_i : b_stop_i;
   assign m_st     = (mode == MRG_ISECT) ? late_st : early_st;
   assign m_sp     = (mode == MRG_ISECT) ? early_sp : late_sp;
   assign m_apart  = (a_start_i > b_stop_i) || (b_start_i > a_stop_i);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            done_o  <= 1'b0;
            start_o <= '0;
            stop_o  <= '0;
            apart_o <= 1'b0;
         end else begin
            done_o <= valid_i;
            if (valid_i) begin
               start_o <= m_st;
               stop_o  <= m_sp;
               apart_o <= m_apart;
            end
         end
      end
   end else begin : g_comb
      assign done_o  = valid_i;
      assign start_o = m_st;
      assign stop_o  = m_sp;
      assign apart_o = m_apart;
   end

endmodule

// File: rtl/cwin_hit.sv
module cwin_hit #(
   parameter int TW = 16
) (
   input  logic signed [TW-1:0] win_start_i,
   input  logic signed [TW-1:0] win_stop_i,
   input  logic signed [TW-1:0] hit_i,
   output logic                 coinc_o
);
   logic after_start, before_stop;
   assign after_start = hit_i > win_start_i;
   assign before_stop = hit_i < win_stop_i;
   assign coinc_o     = after_start && before_stop;
endmodule

// File: rtl/cwin_gen.sv
module cwin_gen #(
   parameter int PW      = 5,
   parameter int LW      = 8,
   parameter int DW      = 10,
   parameter int TW      = 16,
   parameter int STEP    = 500,
   parameter int BASE_HI = -500,
   parameter int BASE_LO = -3000,
   parameter bit MRG_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_valid,
   input  logic [PW-1:0]        cfg_profile,
   input  logic [LW-1:0]        cfg_latch,
   input  logic [LW-1:0]        cfg_reset,
   input  logic [DW-1:0]        cfg_delay,
   output logic                 win_done,
   output logic signed [TW-1:0] win_start,
   output logic signed [TW-1:0] win_stop,
   output logic                 win_none,
   input  logic                 mrg_valid,
   input  logic                 mrg_and,
   input  logic signed [TW-1:0] a_start,
   input  logic signed [TW-1:0] a_stop,
   input  logic signed [TW-1:0] b_start,
   input  logic signed [TW-1:0] b_stop,
   output logic                 mrg_done,
   output logic signed [TW-1:0] mrg_start,
   output logic signed [TW-1:0] mrg_stop,
   output logic                 mrg_apart,
   input  logic signed [TW-1:0] hit_time,
   output logic                 hit_coinc
);
   logic scan_busy;

   cwin_scan #(
      .PW(PW), .LW(LW), .DW(DW), .TW(TW),
      .STEP(STEP), .BASE_HI(BASE_HI), .BASE_LO(BASE_LO)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (cfg_valid),
      .profile_i (cfg_profile),
      .latch_i   (cfg_latch),
      .reset_i   (cfg_reset),
      .delay_i   (cfg_delay),
      .busy_o    (scan_busy),
      .done_o    (win_done),
      .start_o   (win_start),
      .stop_o    (win_stop),
      .none_o    (win_none)
   );

   cwin_merge #(.TW(TW), .REG_OUT(MRG_REG)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (mrg_valid),
      .and_i     (mrg_and),
      .a_start_i (a_start),
      .a_stop_i  (a_stop),
      .b_start_i (b_start),
      .b_stop_i  (b_stop),
      .done_o    (mrg_done),
      .start_o   (mrg_start),
      .stop_o    (mrg_stop),
      .apart_o   (mrg_apart)
   );

   cwin_hit #(.TW(TW)) u_hit (
      .win_start_i (win_start),
      .win_stop_i  (win_stop),
      .hit_i       (hit_time),
      .coinc_o     (hit_coinc)
   );

endmodule

// File: rtl/cwin_gen_chk.sv
module cwin_gen_chk #(
   parameter int PW = 5,
   parameter int TW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_valid,
   input logic                 busy,
   input logic                 win_done,
   input logic signed [TW-1:0] win_start,
   input logic signed [TW-1:0] win_stop,
   input logic                 win_none,
   input logic                 mrg_valid,
   input logic                 mrg_done,
   input logic                 hit_coinc
);
   localparam int SLOTS = 2 * PW + 1;
   localparam int CW    = $clog2(SLOTS) + 2;

   logic [CW-1:0] lat_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                  lat_cnt <= '0;
      else if (cfg_valid && !busy) lat_cnt <= CW'(1);
      else if (win_done)           lat_cnt <= '0;
      else if (lat_cnt != '0)      lat_cnt <= lat_cnt + CW'(1);
   end

   // R6: result arrives a fixed number of cycles after acceptance
   p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |-> lat_cnt == CW'(SLOTS));

   // R6: done is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |=> !win_done);

   // R6: window holds between pulses
   p_win_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !win_done |-> ($stable(win_start) && $stable(win_stop) && $stable(win_none)));

   // R5: an incomplete window leaves stop at zero
   p_none_stop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && win_none) |-> win_stop == '0);

   // R4: a complete window stops after it starts
   p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && !win_none) |-> win_stop > win_start);

   // R11: merge result follows its strobe by one cycle
   p_merge_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mrg_done |-> $past(mrg_valid));

   // R12: a coincidence needs a non-empty open interval
   p_hit_needs_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hit_coinc |-> (win_stop > win_start));

endmodule

bind cwin_gen cwin_gen_chk #(.PW(PW), .TW(TW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_valid (cfg_valid),
   .busy      (scan_busy),
   .win_done  (win_done),
   .win_start (win_start),
   .win_stop  (win_stop),
   .win_none  (win_none),
   .mrg_valid (mrg_valid),
   .mrg_done  (mrg_done),
   .hit_coinc (hit_coinc)
);

// File: tb/cwin_gen_tb.sv
`timescale 1ns/1ps
module cwin_gen_tb;
   localparam int TW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_valid = 1'b0;
   logic [4:0] cfg_profile = '0;
   logic [7:0] cfg_latch = '0, cfg_reset = '0;
   logic [9:0] cfg_delay = '0;
   logic win_done, win_none;
   logic signed [TW-1:0] win_start, win_stop;
   logic mrg_valid = 1'b0, mrg_and = 1'b0;
   logic signed [TW-1:0] a_start = '0, a_stop = '0, b_start = '0, b_stop = '0;
   logic mrg_done, mrg_apart;
   logic signed [TW-1:0] mrg_start, mrg_stop;
   logic signed [TW-1:0] hit_time = '0;
   logic hit_coinc;

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cwin_gen u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_profile(cfg_profile),
      .cfg_latch(cfg_latch), .cfg_reset(cfg_reset), .cfg_delay(cfg_delay),
      .win_done(win_done), .win_start(win_start), .win_stop(win_stop), .win_none(win_none),
      .mrg_valid(mrg_valid), .mrg_and(mrg_and), .a_start(a_start), .a_stop(a_stop),
      .b_start(b_start), .b_stop(b_stop), .mrg_done(mrg_done), .mrg_start(mrg_start),
      .mrg_stop(mrg_stop), .mrg_apart(mrg_apart), .hit_time(hit_time), .hit_coinc(hit_coinc)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // expected window from the requirement text (R2..R5)
   function automatic void ref_win(input logic [4:0] p, input int lat, input int rst,
                                   input int dly, output int s, output int sp, output bit none);
      bit sl[11];
      int base, ri, fi;
      bit rise, fall;
      sl[0] = p[0];
      for (int j = 0; j < 5; j++) begin
         sl[1 + j] = p[4 - j];
         sl[6 + j] = p[4 - j];
      end
      base = (rst >= lat) ? -500 : -3000;
      rise = 0; fall = 0; ri = 0; fi = 0;
      for (int i = 1; i < 11; i++) begin
         if (!rise && !sl[i-1] && sl[i]) begin rise = 1; ri = i; end
         else if (rise && !fall && sl[i-1] && !sl[i]) begin fall = 1; fi = i; end
      end
      s    = rise ? base + 500 * ri + dly : 0;
      sp   = (rise && fall) ? base + 500 * fi + dly : 0;
      none = !(rise && fall);
   endfunction

   // runs one scan; optional second strobe mid-scan (R7)
   task automatic run_scan(input logic [4:0] p, input int lat, input int rst, input int dly,
                           input bit poke, input string req);
      int es, esp;
      bit en;
      ref_win(p, lat, rst, dly, es, esp, en);
      @(negedge clk);
      cfg_profile = p; cfg_latch = 8'(lat); cfg_reset = 8'(rst); cfg_delay = 10'(dly);
      cfg_valid = 1'b1;
      @(negedge clk);
      cfg_valid = 1'b0;
      for (int k = 2; k <= 11; k++) begin
         if (poke && k == 4) begin
            cfg_profile = ~p; cfg_delay = 10'(dly + 7); cfg_latch = 8'(rst + 1);
            cfg_valid = 1'b1;
         end
         @(negedge clk);
         cfg_valid = 1'b0;
         if (k == 10) check(win_done == 1'b0, "R6 early done", int'(win_done), 0);
      end
      check(win_done == 1'b1, "R6 done due", int'(win_done), 1);
      check(int'(win_start) == es, {req, " start (R3)"}, int'(win_start), es);
      check(int'(win_stop) == esp, {req, " stop (R4)"}, int'(win_stop), esp);
      check(win_none == en, {req, " none (R5)"}, int'(win_none), int'(en));
      @(negedge clk);
      check(win_done == 1'b0 && int'(win_start) == es && int'(win_stop) == esp,
            "R6 pulse drop and hold", int'(win_done), 0);
   endtask

   task automatic run_merge(input int as, input int ae, input int bs, input int be,
                            input bit is_and);
      int es, esp;
      bit eap;
      if (is_and) begin
         es  = (as > bs) ? as : bs;
         esp = (ae < be) ? ae : be;
      end else begin
         es  = (as < bs) ? as : bs;
         esp = (ae > be) ? ae : be;
      end
      eap = (as > be) || (bs > ae);
      @(negedge clk);
      a_start = TW'(as); a_stop = TW'(ae); b_start = TW'(bs); b_stop = TW'(be);
      mrg_and = is_and; mrg_valid = 1'b1;
      @(negedge clk);
      mrg_valid = 1'b0;
      check(mrg_done == 1'b1, "R11 merge done", int'(mrg_done), 1);
      check(int'(mrg_start) == es, is_and ? "R9 start" : "R8 start", int'(mrg_start), es);
      check(int'(mrg_stop) == esp, is_and ? "R9 stop" : "R8 stop", int'(mrg_stop), esp);
      check(mrg_apart == eap, "R10 apart", int'(mrg_apart), int'(eap));
      @(negedge clk);
      check(mrg_done == 1'b0 && int'(mrg_start) == es, "R11 pulse and hold", int'(mrg_done), 0);
   endtask

   task automatic try_hit(input int t);
      bit e;
      hit_time = TW'(t);
      #1;
      e = (t > int'(win_start)) && (t < int'(win_stop));
      check(hit_coinc == e, "R12 hit", int'(hit_coinc), int'(e));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(win_done == 0, "R1 win_done", int'(win_done), 0);
      check(win_start == 0 && win_stop == 0, "R1 window zero", int'(win_start), 0);
      check(win_none == 1, "R1 win_none", int'(win_none), 1);
      check(mrg_done == 0, "R1 mrg_done", int'(mrg_done), 0);
      try_hit(0);

      // directed: R2 base choice and slot order
      run_scan(5'b10000, 3, 9, 0, 0, "R2 hi base");     // 0 / 500
      try_hit(0); try_hit(1); try_hit(499); try_hit(500); try_hit(-1); try_hit(250);
      run_scan(5'b00001, 9, 3, 100, 0, "R2 lo base");   // -400 / 100
      run_scan(5'b01111, 5, 5, 0, 0, "R2 equal");       // 500 / 2500
      run_scan(5'b00011, 0, 1, 1023, 0, "R3 max delay");
      run_scan(5'b00000, 1, 2, 40, 0, "R5 all zero");
      try_hit(0);
      run_scan(5'b11111, 2, 1, 40, 0, "R5 all one");
      run_scan(5'b10101, 1, 2, 12, 0, "R4 first fall only");
      run_scan(5'b01101, 4, 4, 33, 1, "R7 busy strobe");

      // random scans with hit probes
      for (int n = 0; n < 40; n++) begin
         logic [4:0] p;
         p = 5'($urandom);
         run_scan(p, int'($urandom % 256), int'($urandom % 256), int'($urandom % 1024),
                  bit'($urandom % 4 == 0), "R3 random");
         try_hit(int'(win_start)); try_hit(int'(win_stop));
         try_hit(int'(win_start) + 1); try_hit(int'(win_stop) - 1);
         try_hit(int'($urandom % 6000) - 3000);
      end

      // directed merges
      run_merge(0, 500, 200, 900, 0);
      run_merge(0, 500, 200, 900, 1);
      run_merge(-300, 100, 400, 900, 0);   // B after A
      run_merge(400, 900, -300, 100, 1);   // A after B
      run_merge(0, 500, 500, 700, 1);      // touching, not apart
      for (int n = 0; n < 40; n++) begin
         int as, bs;
         as = int'($urandom % 6000) - 3000;
         bs = int'($urandom % 6000) - 3000;
         run_merge(as, as + int'($urandom % 3000), bs, bs + int'($urandom % 3000),
                   bit'($urandom % 2));
      end

      finish_run();
   end

endmodule